// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits on a simple word-wide register bus and fronts an array of 128 fuse words, each 32 bits wide. A bank of shadow registers holds a copy of every fuse word, and ordinary reads are served from that bank. Software puts a word index and a 16-bit unlock key into the control register. A write to the data register then starts one programming run. The run first senses the current fuse word and removes every bit that is already burnt from the request. It then steps through the 32 bit positions one at a time. A fuse bit can be set but never cleared.

Per-word write-lock and read-lock vectors come in on input ports. A refused access raises a sticky error flag. A read of a read-locked word returns a fixed poison pattern. Software can copy the whole fuse array into the shadow bank on request. All strobe and recovery lengths come from a timing register and are counted in clock cycles.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control word reads 0, the timing register reads its reset value 0x0001_1002, and every shadow word reads 0.
- R2: The control word is at offset 0x00, its set alias at 0x04 and its clear alias at 0x08. The word index is in bits [6:0] and the key field in bits [31:16]. A direct write loads both fields. The set alias ORs them in and the clear alias removes the bits written as 1.
- R3: A data-register write (offset 0x20) while the key field holds 0x3E77, with the block idle and error clear, starts a run. From the next cycle, busy (bit 8) is set and the key field reads 0. The run's word index is captured at the start, and later control writes do not move it.
- R4: The fuse word after a run equals its old value OR the data written. The data register is first reduced to the bits not yet burnt, so 0 bits and already-burnt bits leave the fuse as it was.
- R5: During a run the data register shifts right by one with zero fill after each bit step, and bus writes to it are dropped. It reads 0 when the run ends.
- R6: With read length r, strobe length p and recovery length x taken from the timing register, busy stays high for exactly (r+1) + 32*(p+1+x+1) cycles.
- R7: A start attempt on a word whose write-lock input is high never sets busy, leaves the fuse unchanged, clears the key field and sets error (bit 9).
- R8: A read of shadow word i sits at 0x400 + 0x10*i. For a word whose read-lock input is high it returns 0xBADA_BADA and sets error.
- R9: Error stays set until a clear-alias write with bit 9 set. While error is set, start, reload, shadow reads (which return 0) and shadow writes are refused.
- R10: A set-alias write with bit 10 set while idle copies every fuse word into its shadow. Bit 10 and busy read 1 for exactly 128*(r+1) cycles, and both clear at the end.
- R11: A shadow write while idle to a word that is not write-locked stores the value. A shadow write while busy, or to a write-locked word, sets error and keeps the old contents.
- R12: While busy, start and reload requests are dropped without raising error, and shadow reads return 0.
- R13: The timing register at offset 0x10 keeps the strobe length in [11:0], the recovery length in [15:12] and the read length in [21:16]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| wr_lock | input | 128 | Per-word program and shadow-write lock |
| rd_lock | input | 128 | Per-word read lock |

## Verification
The assertions assume the lock vectors stay constant while a run is in flight, and that every bus access lasts exactly one cycle. They also assume software does not rewrite the timing register while busy, because the duration checks depend on fixed lengths. The stimulus changes locks only while the block is idle, and it programs the timing register once, before any run. Every access is a single-cycle pulse. Reads land on cycles computed from the timing values, so the first and last busy cycles can be observed exactly.

// File: rtl/otp_pkg.sv
// Shared constants for the fuse controller: bus offsets, control-word bit
// positions, the unlock key, the poison pattern and the sequencer states.
package otp_pkg;
    localparam int OFS_CTRL   = 'h000;
    localparam int OFS_SET    = 'h004;
    localparam int OFS_CLR    = 'h008;
    localparam int OFS_TIMING = 'h010;
    localparam int OFS_DATA   = 'h020;
    localparam int SHD_BASE   = 'h400;
    localparam int SHD_STRIDE = 'h10;

    localparam int BUSY_BIT   = 8;
    localparam int ERR_BIT    = 9;
    localparam int RLD_BIT    = 10;
    localparam int KEY_LSB    = 16;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
    localparam logic [31:0] POISON     = 32'hBADA_BADA;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRD,
        SQ_PSTB,
        SQ_PRLX,
        SQ_RLD
    } sq_state_e;
endpackage

// File: rtl/otp_step_timer.sv
// Cycle counter for one phase of the sequencer.
// Assumes: the owner restarts it at every phase change; hit is high in the
// last cycle of a phase that lasts limit+1 cycles.
module otp_step_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          hit
);
    logic [TW-1:0] cnt_q;

    assign hit = (cnt_q == limit);

    // Count cycles inside a phase, back to zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/otp_fuse_store.sv
// Behavioural fuse array plus shadow bank.
// Assumes: burn_en only sets one bit of word rd_idx; copy_en and shd_we
// never hit the same word in the same cycle (the top gates writes by busy).
module otp_fuse_store #(
    parameter int WORDS = 128,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS),
    localparam int BW   = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] fuse_rdata,
    input  logic          burn_en,
    input  logic [BW-1:0] burn_bit,
    input  logic          copy_en,
    input  logic          shd_we,
    input  logic [AW-1:0] shd_widx,
    input  logic [DW-1:0] shd_wdata,
    input  logic [AW-1:0] shd_ridx,
    output logic [DW-1:0] shd_rdata
);
    logic [DW-1:0] fuse_q [WORDS];
    logic [DW-1:0] shd_q  [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Fuse word: bits can only be set by a burn strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fuse_q[w] <= '0;
            else if (burn_en && rd_idx == AW'(w))
                fuse_q[w][burn_bit] <= 1'b1;
        end

        // Shadow word: loaded by reload copy or a bus write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shd_q[w] <= '0;
            else if (copy_en && rd_idx == AW'(w))
                shd_q[w] <= fuse_q[w];
            else if (shd_we && shd_widx == AW'(w))
                shd_q[w] <= shd_wdata;
        end
    end

    assign fuse_rdata = fuse_q[rd_idx];
    assign shd_rdata  = shd_q[shd_ridx];

    AST_FUSE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_idx) |-> ((fuse_rdata & $past(fuse_rdata)) == $past(fuse_rdata))); // R4
endmodule

// File: rtl/otp_prog_seq.sv
// Sequencer for programming runs and shadow reloads.
// A run has one sense phase, then 32 steps of strobe plus recovery.
// A reload has one sense phase per word.
// Assumes: start pulses arrive only while busy is low; timing is stable.
module otp_prog_seq #(
    parameter int WORDS = 128,
    parameter int DW    = 32,
    parameter int TW    = 12,
    localparam int AW   = $clog2(WORDS),
    localparam int BW   = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_prog,
    input  logic          start_reload,
    input  logic [AW-1:0] prog_addr,
    input  logic [11:0]   tim_prog,
    input  logic [3:0]    tim_relax,
    input  logic [5:0]    tim_read,
    output logic          busy,
    output logic          reloading,
    output logic [AW-1:0] rd_idx,
    output logic [BW-1:0] bit_idx,
    output logic          mask_en,
    output logic          burn_en,
    output logic          shift_en,
    output logic          copy_en
);
    import otp_pkg::*;

    sq_state_e     state_q;
    logic [AW-1:0] tgt_q;
    logic [AW-1:0] widx_q;
    logic [BW-1:0] bit_q;
    logic [TW-1:0] limit;
    logic          hit;
    logic          restart;

    // Select the phase length from the timing fields.
    always_comb begin
        case (state_q)
            SQ_PRD, SQ_RLD: limit = TW'(tim_read);
            SQ_PSTB:        limit = TW'(tim_prog);
            SQ_PRLX:        limit = TW'(tim_relax);
            default:        limit = '0;
        endcase
    end

    assign restart = (state_q == SQ_IDLE) || hit;

    otp_step_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .hit     (hit)
    );

    // Advance the phase state, target word, bit step and reload index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            tgt_q   <= '0;
            widx_q  <= '0;
            bit_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start_prog) begin
                        tgt_q   <= prog_addr;
                        bit_q   <= '0;
                        state_q <= SQ_PRD;
                    end else if (start_reload) begin
                        widx_q  <= '0;
                        state_q <= SQ_RLD;
                    end
                end
                SQ_PRD:  if (hit) state_q <= SQ_PSTB;
                SQ_PSTB: if (hit) state_q <= SQ_PRLX;
                SQ_PRLX: begin
                    if (hit) begin
                        if (bit_q == BW'(DW-1)) begin
                            state_q <= SQ_IDLE;
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            state_q <= SQ_PSTB;
                        end
                    end
                end
                SQ_RLD: begin
                    if (hit) begin
                        if (widx_q == AW'(WORDS-1)) state_q <= SQ_IDLE;
                        else                        widx_q  <= widx_q + 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != SQ_IDLE);
    assign reloading = (state_q == SQ_RLD);
    assign rd_idx    = reloading ? widx_q : tgt_q;
    assign bit_idx   = bit_q;
    assign mask_en   = (state_q == SQ_PRD)  && hit;
    assign burn_en   = (state_q == SQ_PSTB) && hit;
    assign shift_en  = (state_q == SQ_PRLX) && hit;
    assign copy_en   = (state_q == SQ_RLD)  && hit;
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Top of the fuse controller: bus decode, control/timing/data registers,
// the error flag, and the glue to the sequencer and fuse store.
// Assumes: single-cycle bus accesses; read data is combinational; lock
// inputs are stable while a run is in flight.
module otp_fuse_ctrl #(
    parameter int          WORDS     = 128,
    parameter int          DW        = 32,
    parameter int          BUS_AW    = 12,
    parameter logic [31:0] TIM_RESET = 32'h0001_1002,
    localparam int         AW        = $clog2(WORDS),
    localparam int         BW        = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [WORDS-1:0]  wr_lock,
    input  logic [WORDS-1:0]  rd_lock
);
    import otp_pkg::*;

    localparam logic [BUS_AW-1:0] SHD_LO  = BUS_AW'(SHD_BASE);
    localparam logic [BUS_AW-1:0] SHD_LEN = BUS_AW'(WORDS * SHD_STRIDE);

    logic [AW-1:0] addr_q;
    logic [15:0]   key_q;
    logic          err_q;
    logic [DW-1:0] data_q;
    logic [11:0]   tprog_q;
    logic [3:0]    trelax_q;
    logic [5:0]    tread_q;

    logic busy, reloading, mask_en, burn_en, shift_en, copy_en;
    logic [AW-1:0] rd_idx;
    logic [BW-1:0] bit_idx;
    logic [DW-1:0] fuse_rdata, shd_rdata;

    // Address decode.
    logic [BUS_AW-1:0] shd_off;
    logic [AW-1:0]     shd_idx;
    logic in_shd, wr_ctrl, wr_set, wr_clr, wr_tim, wr_data, wr_shd, rd_shd;

    assign shd_off = bus_addr - SHD_LO;
    assign shd_idx = shd_off[AW+3:4];
    assign in_shd  = (bus_addr >= SHD_LO) && (shd_off < SHD_LEN) && (shd_off[3:0] == 4'h0);
    assign wr_ctrl = bus_en && bus_wr && (bus_addr == BUS_AW'(OFS_CTRL));
    assign wr_set  = bus_en && bus_wr && (bus_addr == BUS_AW'(OFS_SET));
    assign wr_clr  = bus_en && bus_wr && (bus_addr == BUS_AW'(OFS_CLR));
    assign wr_tim  = bus_en && bus_wr && (bus_addr == BUS_AW'(OFS_TIMING));
    assign wr_data = bus_en && bus_wr && (bus_addr == BUS_AW'(OFS_DATA));
    assign wr_shd  = bus_en && bus_wr && in_shd;
    assign rd_shd  = bus_en && !bus_wr && in_shd;

    // Request qualification.
    logic prog_try, prog_go, rld_go, shd_we, err_set, err_clr;

    assign prog_try = wr_data && !busy && (key_q == UNLOCK_KEY);
    assign prog_go  = prog_try && !err_q && !wr_lock[addr_q];
    assign rld_go   = wr_set && bus_wdata[RLD_BIT] && !busy && !err_q;
    assign shd_we   = wr_shd && !err_q && !busy && !wr_lock[shd_idx];
    assign err_clr  = wr_clr && bus_wdata[ERR_BIT];
    assign err_set  = (prog_try && !err_q && wr_lock[addr_q])
                    || (rd_shd && !busy && !err_q && rd_lock[shd_idx])
                    || (wr_shd && !err_q && (busy || wr_lock[shd_idx]));

    // Control fields: word index and unlock key, with set/clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            key_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                addr_q <= bus_wdata[AW-1:0];
                key_q  <= bus_wdata[KEY_LSB +: 16];
            end else if (wr_set) begin
                addr_q <= addr_q | bus_wdata[AW-1:0];
                key_q  <= key_q  | bus_wdata[KEY_LSB +: 16];
            end else if (wr_clr) begin
                addr_q <= addr_q & ~bus_wdata[AW-1:0];
                key_q  <= key_q  & ~bus_wdata[KEY_LSB +: 16];
            end
            if (prog_try) key_q <= '0;
        end
    end

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_clr) err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end

    // Data register: bus load when idle, mask and shift during a run.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (wr_data && !busy) data_q <= bus_wdata;
        else if (mask_en)          data_q <= data_q & ~fuse_rdata;
        else if (shift_en)         data_q <= data_q >> 1;
    end

    // Timing register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tprog_q  <= TIM_RESET[11:0];
            trelax_q <= TIM_RESET[15:12];
            tread_q  <= TIM_RESET[21:16];
        end else if (wr_tim) begin
            tprog_q  <= bus_wdata[11:0];
            trelax_q <= bus_wdata[15:12];
            tread_q  <= bus_wdata[21:16];
        end
    end

    otp_prog_seq #(.WORDS(WORDS), .DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_prog   (prog_go),
        .start_reload (rld_go),
        .prog_addr    (addr_q),
        .tim_prog     (tprog_q),
        .tim_relax    (trelax_q),
        .tim_read     (tread_q),
        .busy         (busy),
        .reloading    (reloading),
        .rd_idx       (rd_idx),
        .bit_idx      (bit_idx),
        .mask_en      (mask_en),
        .burn_en      (burn_en),
        .shift_en     (shift_en),
        .copy_en      (copy_en)
    );

    otp_fuse_store #(.WORDS(WORDS), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rd_idx),
        .fuse_rdata (fuse_rdata),
        .burn_en    (burn_en && data_q[0]),
        .burn_bit   (bit_idx),
        .copy_en    (copy_en),
        .shd_we     (shd_we),
        .shd_widx   (shd_idx),
        .shd_wdata  (bus_wdata),
        .shd_ridx   (shd_idx),
        .shd_rdata  (shd_rdata)
    );

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (in_shd) begin
            if (!busy && !err_q)
                bus_rdata = rd_lock[shd_idx] ? POISON : shd_rdata;
        end else begin
            case (bus_addr)
                BUS_AW'(OFS_CTRL), BUS_AW'(OFS_SET), BUS_AW'(OFS_CLR): begin
                    bus_rdata[AW-1:0]          = addr_q;
                    bus_rdata[BUSY_BIT]        = busy;
                    bus_rdata[ERR_BIT]         = err_q;
                    bus_rdata[RLD_BIT]         = reloading;
                    bus_rdata[KEY_LSB +: 16]   = key_q;
                end
                BUS_AW'(OFS_TIMING): begin
                    bus_rdata[11:0]  = tprog_q;
                    bus_rdata[15:12] = trelax_q;
                    bus_rdata[21:16] = tread_q;
                end
                BUS_AW'(OFS_DATA): bus_rdata = data_q;
                default:           bus_rdata = '0;
            endcase
        end
    end

    AST_KEY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !reloading) |-> (key_q == '0)); // R3
    AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reloading && $past(busy && !reloading)) |-> $stable(rd_idx)); // R3
    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reloading && !mask_en && !shift_en) |=> $stable(data_q)); // R5
    AST_LOCK_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_try && !err_q && wr_lock[addr_q]) |=> (!busy && err_q)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q); // R9
    AST_RELOAD_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reloading) |-> !busy); // R10
endmodule

// File: tb/sim_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module sim_otp_fuse_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_en = 1'b0;
    logic         bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] wr_lock = '0;
    logic [127:0] rd_lock = '0;

    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        chk_now = 1'b0;

    always #2 clk = ~clk;

    otp_fuse_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wr_lock   (wr_lock),
        .rd_lock   (rd_lock)
    );

    function automatic logic [11:0] shd(input int i);
        return 12'(12'h400 + 12'h10 * i);
    endfunction

    // Monitor: pop the expected item and compare it with the read data.
    always @(negedge clk) begin
        if (chk_now) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata !== e) begin
                n_err++;
                $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    // Driver tasks: entered just after a rising edge, one cycle each.
    task automatic op_wr(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic op_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a; chk_now = 1'b1;
        @(posedge clk); #1;
        bus_en = 1'b0; chk_now = 1'b0;
    endtask

    task automatic op_peek(input logic [11:0] a, output logic [31:0] v);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_done(input string t);
        logic [31:0] v;
        bit          done = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            op_peek(12'h000, v);
            if (!v[8]) begin
                done = 1'b1;
                break;
            end
        end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL %s: busy got 1 expected 0", t);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL R6 watchdog: got running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1 reset state
        op_rd(12'h000, 32'h0000_0000, "R1 ctrl");
        op_rd(12'h010, 32'h0001_1002, "R1 timing");
        op_rd(shd(5),  32'h0000_0000, "R1 shadow");

        // R13 timing fields: read=3 relax=1 strobe=2
        op_wr(12'h010, 32'hFFC3_1002);
        op_rd(12'h010, 32'h0003_1002, "R13 timing fields");

        // R2 control word and aliases
        op_wr(12'h000, 32'h3E77_0005);
        op_rd(12'h000, 32'h3E77_0005, "R2 direct");
        op_wr(12'h004, 32'h0000_0002);
        op_rd(12'h000, 32'h3E77_0007, "R2 set alias");
        op_wr(12'h008, 32'h0000_0003);
        op_rd(12'h004, 32'h3E77_0004, "R2 clear alias");
        op_wr(12'h008, 32'h3E77_0000);
        op_rd(12'h008, 32'h0000_0004, "R2 clear key");

        // R3/R5/R6 first run on word 10
        op_wr(12'h000, 32'h3E77_000A);
        op_wr(12'h020, 32'hA5A5_0F0F);
        op_wr(12'h020, 32'hFFFF_FFFF);
        op_rd(12'h020, 32'hA5A5_0F0F, "R5 write dropped");
        op_rd(12'h000, 32'h0000_010A, "R3 busy and key clear");
        op_wr(12'h000, 32'h0000_0014);
        idle(159);
        op_rd(12'h000, 32'h0000_0114, "R6 last busy cycle");
        op_rd(12'h000, 32'h0000_0014, "R6 busy cleared");
        op_rd(12'h020, 32'h0000_0000, "R5 shifted out");

        // R10 reload timing
        op_wr(12'h004, 32'h0000_0400);
        op_rd(12'h000, 32'h0000_0514, "R10 reload busy");
        idle(510);
        op_rd(12'h000, 32'h0000_0514, "R10 last reload cycle");
        op_rd(12'h000, 32'h0000_0014, "R10 reload done");
        op_rd(shd(10), 32'hA5A5_0F0F, "R4 first burn");
        op_rd(shd(20), 32'h0000_0000, "R3 latched target");

        // R4 masking on a second run
        op_wr(12'h000, 32'h3E77_000A);
        op_wr(12'h020, 32'h0F0F_F0F0);
        idle(4);
        op_rd(12'h020, 32'h0A0A_F0F0, "R4 masked data");
        wait_done("R4 wait");

        // R7 write-locked word
        wr_lock[30] = 1'b1;
        op_wr(12'h000, 32'h3E77_001E);
        op_wr(12'h020, 32'hFFFF_FFFF);
        op_rd(12'h000, 32'h0000_021E, "R7 locked start");

        // R9 refusals while error
        op_wr(12'h004, 32'h0000_0400);
        op_rd(12'h000, 32'h0000_021E, "R9 reload refused");
        op_rd(shd(10), 32'h0000_0000, "R9 read refused");
        op_wr(12'h008, 32'h0000_0200);
        op_rd(12'h000, 32'h0000_001E, "R9 error cleared");
        op_wr(12'h004, 32'h0000_0400);
        wait_done("R10 wait");
        op_rd(shd(30), 32'h0000_0000, "R7 fuse unchanged");
        op_rd(shd(10), 32'hAFAF_FFFF, "R4 merged word");

        // R8 read lock
        rd_lock[10] = 1'b1;
        op_rd(shd(10), 32'hBADA_BADA, "R8 poison");
        op_rd(12'h000, 32'h0000_021E, "R8 error set");
        op_wr(12'h008, 32'h0000_0200);

        // R11 shadow writes
        op_wr(shd(5), 32'h1234_5678);
        op_rd(shd(5), 32'h1234_5678, "R11 stored");
        op_wr(shd(30), 32'h0000_FFFF);
        op_rd(12'h000, 32'h0000_021E, "R11 locked write error");
        op_wr(12'h008, 32'h0000_0200);
        op_rd(shd(30), 32'h0000_0000, "R11 locked kept");
        op_wr(12'h004, 32'h0000_0400);
        op_wr(shd(5), 32'h0000_DEAD);
        op_rd(12'h000, 32'h0000_071E, "R11 busy write error");
        wait_done("R11 wait");
        op_wr(12'h008, 32'h0000_0200);

        // R12 requests while busy
        rd_lock[10] = 1'b0;
        op_wr(12'h000, 32'h3E77_0028);
        op_wr(12'h020, 32'h0000_0001);
        op_rd(shd(10), 32'h0000_0000, "R12 read while busy");
        op_wr(12'h004, 32'h0000_0400);
        wait_done("R12 wait");
        op_rd(12'h000, 32'h0000_0028, "R12 no reload no error");
        op_wr(12'h004, 32'h0000_0400);
        wait_done("R10 wait");
        op_rd(shd(40), 32'h0000_0001, "R3 word 40 burnt");

        idle(2);
        summary();
        $finish;
    end
endmodule